// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

This block is a synthesizable behavioural model of a small synchronous SRAM whose bus can change direction on every clock without idle cycles. Every control and address input is captured on the rising clock edge. Write data lags its address by a fixed number of cycles: one in flow-through timing and two in pipelined timing. Because of this lag, a write's data slot lines up with the data slot of a read issued on a later cycle, so read-write-read traffic runs at full rate.

A static pin selects pipelined timing, which puts a register on the read path and gives a 3-1-1-1 burst profile, or flow-through timing, which gives 2-1-1-1. A second static pin selects linear or interleaved ordering for 4-beat bursts. Data is organised in 9-bit bytes, and bit 8 of each byte holds even parity over bits 0 to 7. The read path checks that parity and flags each byte that fails.

The data bus is split into an input bus and an output bus, and a valid flag marks the output. When the outputs are off, the output bus reads as zero. A read that hits a write still waiting in the late-write pipeline returns the pending bytes merged with the stored word.

Top module: `zt_sram`

## Requirements
- R1: A cycle starts only when ce1_n=0, ce2=1, ce3_n=0 and sleep=0 at the edge. Any other cycle is a deselect: it writes nothing, produces no read data and ends any burst.
- R2: In flow-through mode (pipe_mode=0), read data for an address captured at edge k is on dout with dout_vld=1 from edge k until edge k+1.
- R3: In pipelined mode (pipe_mode=1), read data for an address captured at edge k is on dout with dout_vld=1 from edge k+1 until edge k+2.
- R4: Write data is taken from din one edge after its address edge in flow-through mode and two edges after it in pipelined mode. Byte b occupies din[9b+8:9b], and its enable bw_n[b] (active low) is sampled with the address.
- R5: A write changes only the bytes whose bw_n bit was low. All other bytes of the word keep their stored value.
- R6: Reads and writes may alternate on consecutive cycles with no idle cycle between them. A read to an address whose write data has not yet been stored returns that pending data, merged byte by byte under its enables.
- R7: A cycle with adv=1 continues the active burst. With burst_ilv=0, beat k uses the low two address bits equal to base+k mod 4, and the upper address bits stay fixed. adv=0 loads a new address.
- R8: With burst_ilv=1, beat k of a burst uses the low two address bits equal to base XOR (k mod 4).
- R9: Every beat of a burst keeps the direction chosen on the load cycle, and we_n is ignored on continue cycles. adv=1 with no active burst is treated as a deselect.
- R10: oe_n=1 forces dout_vld=0, dout=0 and par_err=0 at once, without waiting for a clock edge. It does not disturb reads in flight, and dout reads as zero whenever dout_vld=0.
- R11: sleep=1 blocks new cycles and turns the outputs off at once. Write data already due is still stored.
- R12: par_err[b] is high together with valid read data when the stored 9-bit byte b has an odd number of ones, that is, when bit 8 is not the even parity of bits 0 to 7. The stored bits are returned unchanged on dout.
- R13: While rst_n=0, dout_vld=0, dout=0, par_err=0, and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pipe_mode | input | 1 | Static: 1 selects pipelined timing, 0 selects flow-through |
| burst_ilv | input | 1 | Static: 1 selects interleaved burst order, 0 selects linear |
| addr | input | AW | Word address, used on load cycles |
| adv | input | 1 | 1 continues the burst, 0 loads a new address |
| we_n | input | 1 | Write when low on a load cycle |
| bw_n | input | NB | Per-byte write enables, active low |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Power-down request, active high |
| din | input | NB*9 | Write data bus |
| dout | output | NB*9 | Read data bus, zero when not valid |
| dout_vld | output | 1 | Read data valid |
| par_err | output | NB | Per-byte parity error, reported with the read data |

## Verification
Read data falls due one cycle after the address cycle in flow-through mode and two cycles after it in pipelined mode. Write data must be supplied one or two cycles after its address cycle, depending on the mode. The driver stamps each read with its due cycle as it issues it, and it schedules each write's data for the exact cycle on which the write is taken. The reference memory is updated at the capturing edge, and the monitor compares at the falling edge of the due cycle, so each expectation covers exactly the writes the design has stored or is forwarding. Output enable and sleep are judged by their values during the due cycle, which exposes any sampling of those inputs that should have been asynchronous.

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int AW = 6,
  parameter int NB = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pipe_mode,
  input  logic            burst_ilv,
  input  logic [AW-1:0]   addr,
  input  logic            adv,
  input  logic            we_n,
  input  logic [NB-1:0]   bw_n,
  input  logic            ce1_n,
  input  logic            ce2,
  input  logic            ce3_n,
  input  logic            oe_n,
  input  logic            sleep,
  input  logic [NB*9-1:0] din,
  output logic [NB*9-1:0] dout,
  output logic            dout_vld,
  output logic [NB-1:0]   par_err
);
  localparam int DW    = NB * 9;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  logic          sel, load, cont, cyc_wr, cyc_rd;
  logic          brst_act, brst_wr;
  logic [AW-1:0] brst_base, cyc_addr;
  logic [1:0]    beat, beat_nx, low_nx;

  logic          w1_v, w2_v, wd_v;
  logic [AW-1:0] w1_a, w2_a, wd_a;
  logic [NB-1:0] w1_be, w2_be, wd_be;

  logic          rd_v1, rd_v2, hit, out_v;
  logic [AW-1:0] ra;
  logic [DW-1:0] rd_word, fwd_word, oreg, out_word;

  assign sel      = !ce1_n && ce2 && !ce3_n && !sleep;
  assign load     = sel && !adv;
  assign cont     = sel && adv && brst_act;
  assign beat_nx  = beat + 2'd1;
  assign low_nx   = burst_ilv ? (brst_base[1:0] ^ beat_nx) : (brst_base[1:0] + beat_nx);
  assign cyc_addr = load ? addr : {brst_base[AW-1:2], low_nx};
  assign cyc_wr   = (load && !we_n) || (cont && brst_wr);
  assign cyc_rd   = (load && we_n) || (cont && !brst_wr);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      brst_act  <= 1'b0;
      brst_wr   <= 1'b0;
      brst_base <= '0;
      beat      <= '0;
    end else if (load) begin
      brst_act  <= 1'b1;
      brst_wr   <= !we_n;
      brst_base <= addr;
      beat      <= '0;
    end else if (cont) begin
      beat      <= beat_nx;
    end else begin
      brst_act  <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      w1_v  <= 1'b0;
      w1_a  <= '0;
      w1_be <= '0;
      w2_v  <= 1'b0;
      w2_a  <= '0;
      w2_be <= '0;
      rd_v1 <= 1'b0;
      rd_v2 <= 1'b0;
      ra    <= '0;
      oreg  <= '0;
    end else begin
      w1_v  <= cyc_wr;
      w1_a  <= cyc_addr;
      w1_be <= ~bw_n;
      w2_v  <= w1_v;
      w2_a  <= w1_a;
      w2_be <= w1_be;
      rd_v1 <= cyc_rd;
      rd_v2 <= rd_v1;
      if (cyc_rd) ra <= cyc_addr;
      if (rd_v1) oreg <= fwd_word;
    end

  assign wd_v  = pipe_mode ? w2_v  : w1_v;
  assign wd_a  = pipe_mode ? w2_a  : w1_a;
  assign wd_be = pipe_mode ? w2_be : w1_be;

  always_ff @(posedge clk)
    if (wd_v)
      for (int b = 0; b < NB; b++)
        if (wd_be[b]) mem[wd_a][b*9 +: 9] <= din[b*9 +: 9];

  assign rd_word  = mem[ra];
  assign hit      = wd_v && (wd_a == ra);
  assign out_word = pipe_mode ? oreg : rd_word;
  assign out_v    = pipe_mode ? rd_v2 : rd_v1;
  assign dout_vld = out_v && !oe_n && !sleep;
  assign dout     = dout_vld ? out_word : '0;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign fwd_word[b*9 +: 9] = (hit && wd_be[b]) ? din[b*9 +: 9] : rd_word[b*9 +: 9];
    assign par_err[b]         = dout_vld && (^out_word[b*9 +: 9]);
  end

endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
  parameter int NB = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            pipe_mode,
  input logic            adv,
  input logic            we_n,
  input logic            ce1_n,
  input logic            ce2,
  input logic            ce3_n,
  input logic            oe_n,
  input logic            sleep,
  input logic [NB*9-1:0] dout,
  input logic            dout_vld,
  input logic [NB-1:0]   par_err
);
  logic take, rd_load;
  assign take    = !ce1_n && ce2 && !ce3_n && !sleep;
  assign rd_load = take && !adv && we_n;

  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && !take) |=> !dout_vld);  // R1
  AST_FLOW_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && rd_load) |=> (dout_vld || oe_n || sleep));  // R2
  AST_PIPE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && rd_load) |=> ##1 (dout_vld || oe_n || sleep));  // R3
  AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!dout_vld && dout == '0 && par_err == '0));  // R10
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_vld |-> (dout == '0));  // R10
  AST_SLEEP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dout_vld);  // R11
  AST_PERR_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err != '0) |-> dout_vld);  // R12
endmodule

bind zt_sram zt_sram_chk #(.NB(NB)) chk_i (
  .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .adv(adv), .we_n(we_n),
  .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .oe_n(oe_n), .sleep(sleep),
  .dout(dout), .dout_vld(dout_vld), .par_err(par_err)
);

// File: tb/zt_sram_tb_top.sv
`timescale 1ns/1ps
module zt_sram_tb_top;
  localparam int AW = 6;
  localparam int NB = 4;
  localparam int DW = NB * 9;
  localparam int DEPTH = 1 << AW;
  localparam logic [2:0] ACT = 3'b010;
  localparam logic [2:0] OFF = 3'b110;

  logic clk = 1'b0;
  logic rst_n, pipe_mode, burst_ilv, adv, we_n, ce1_n, ce2, ce3_n, oe_n, sleep;
  logic [AW-1:0] addr;
  logic [NB-1:0] bw_n, par_err;
  logic [DW-1:0] din, dout;
  logic dout_vld;

  zt_sram #(.AW(AW), .NB(NB)) dut_i (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .burst_ilv(burst_ilv),
    .addr(addr), .adv(adv), .we_n(we_n), .bw_n(bw_n), .ce1_n(ce1_n), .ce2(ce2),
    .ce3_n(ce3_n), .oe_n(oe_n), .sleep(sleep), .din(din), .dout(dout),
    .dout_vld(dout_vld), .par_err(par_err)
  );

  always #10 clk = ~clk;

  typedef struct { int due; logic [AW-1:0] a; string tag; } rd_t;
  typedef struct { logic [AW-1:0] a; logic [NB-1:0] be; logic [DW-1:0] d; } wr_t;

  rd_t rq[$];
  wr_t wq[int];
  logic [DW-1:0] ref_mem [DEPTH];
  wr_t stg;
  bit stg_v, mon_en, done;
  int cyc, checks, errors;
  string idle_tag = "R1";
  bit nx_oe, nx_slp, nx_ilv;
  bit b_act, b_wr;
  logic [AW-1:0] b_base;
  logic [1:0] b_beat;

  always @(posedge clk) begin
    if (stg_v) begin
      for (int b = 0; b < NB; b++)
        if (stg.be[b]) ref_mem[stg.a][b*9 +: 9] = stg.d[b*9 +: 9];
      stg_v = 1'b0;
    end
    cyc = cyc + 1;
  end

  task automatic chk(input string tag, input logic [DW-1:0] ad, input logic [DW-1:0] ed,
                     input logic av, input logic ev, input logic [NB-1:0] ap, input logic [NB-1:0] ep);
    checks++;
    if (ad !== ed || av !== ev || ap !== ep) begin
      errors++;
      $display("FAIL %s cyc %0d: dout=%h vld=%b perr=%b expected dout=%h vld=%b perr=%b",
               tag, cyc, ad, av, ap, ed, ev, ep);
    end
  endtask

  always @(negedge clk) if (mon_en) begin
    logic [DW-1:0] ed;
    logic ev;
    logic [NB-1:0] ep;
    string tg;
    rd_t it;
    ed = '0; ev = 1'b0; ep = '0; tg = idle_tag;
    while (rq.size() > 0 && rq[0].due < cyc) begin
      it = rq.pop_front();
      checks++; errors++;
      $display("FAIL %s: read due at %0d never compared, actual none expected data", it.tag, it.due);
    end
    if (rq.size() > 0 && rq[0].due == cyc) begin
      it = rq.pop_front();
      tg = it.tag;
      ev = !oe_n && !sleep;
      if (ev) begin
        ed = ref_mem[it.a];
        for (int b = 0; b < NB; b++) ep[b] = ^ed[b*9 +: 9];
      end
    end
    chk(tg, dout, ed, dout_vld, ev, par_err, ep);
  end

  function automatic logic [DW-1:0] pat(input int a, input int salt, input logic [NB-1:0] bad);
    logic [DW-1:0] r;
    for (int b = 0; b < NB; b++) begin
      logic [7:0] v;
      v = 8'(a * 37 + b * 101 + salt);
      r[b*9 +: 9] = {(^v) ^ bad[b], v};
    end
    return r;
  endfunction

  task automatic step(input logic [2:0] ce, input bit a_v, input bit wr, input logic [AW-1:0] a,
                      input logic [NB-1:0] bwn, input logic [DW-1:0] d, input string tag);
    int p;
    bit sl, ld, ct, opw;
    logic [AW-1:0] ae;
    logic [1:0] lo;
    @(posedge clk); #5;
    p = cyc;
    sl = (ce == ACT) && !nx_slp;
    ld = sl && !a_v;
    ct = sl && a_v && b_act;
    ae = a; opw = wr;
    if (ld) begin
      b_act = 1'b1; b_wr = wr; b_base = a; b_beat = 2'd0;
    end else if (ct) begin
      b_beat = b_beat + 2'd1;
      lo = nx_ilv ? (b_base[1:0] ^ b_beat) : (b_base[1:0] + b_beat);
      ae = {b_base[AW-1:2], lo};
      opw = b_wr;
    end else b_act = 1'b0;
    if (ld || ct) begin
      if (opw) wq[p + 1 + int'(pipe_mode)] = '{ae, ~bwn, d};
      else rq.push_back('{p + 1 + int'(pipe_mode), ae, tag});
    end
    {ce1_n, ce2, ce3_n} = ce;
    adv = a_v; we_n = !wr; addr = a; bw_n = bwn;
    oe_n = nx_oe; sleep = nx_slp; burst_ilv = nx_ilv;
    if (wq.exists(p)) begin
      din = wq[p].d; stg = wq[p]; stg_v = 1'b1; wq.delete(p);
    end else din = DW'({$urandom(), $urandom()});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(OFF, 1'b0, 1'b0, '0, '1, '0, "");
  endtask
  task automatic wr(input int a, input logic [NB-1:0] bwn, input logic [DW-1:0] d, input string tag);
    step(ACT, 1'b0, 1'b1, AW'(a), bwn, d, tag);
  endtask
  task automatic rd(input int a, input string tag);
    step(ACT, 1'b0, 1'b0, AW'(a), '1, '0, tag);
  endtask
  task automatic nxt(input bit w, input logic [DW-1:0] d, input string tag);
    step(ACT, 1'b1, w, '1, '0, d, tag);
  endtask

  task automatic do_reset(input bit pm);
    mon_en = 1'b0;
    @(posedge clk); #5;
    rst_n = 1'b0; pipe_mode = pm;
    {ce1_n, ce2, ce3_n} = OFF; adv = 0; we_n = 1; bw_n = '1; oe_n = 0; sleep = 0;
    rq.delete(); wq.delete(); stg_v = 1'b0; b_act = 1'b0;
    nx_oe = 0; nx_slp = 0; nx_ilv = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R13", dout, '0, dout_vld, 1'b0, par_err, '0);
    @(posedge clk); #5;
    rst_n = 1'b1; mon_en = 1'b1;
  endtask

  task automatic run_suite();
    string lat;
    lat = pipe_mode ? "R3" : "R2";
    for (int a = 0; a < DEPTH; a++)
      wr(a, '0, pat(a, 0, a == 5 ? 4'b0010 : (a == 9 ? 4'b1001 : 4'b0000)), "R4");
    idle(3);
    for (int a = 0; a < DEPTH; a++) rd(a, (a == 5 || a == 9) ? "R12" : lat);
    idle(3);
    // R5 byte write
    wr(10, 4'b1010, pat(10, 90, '0), "R5"); idle(3); rd(10, "R5"); idle(3);
    // R6 alternating traffic with forwarding
    rd(20, "R6"); wr(20, '0, pat(20, 1, '0), "R6"); rd(20, "R6");
    wr(21, '0, pat(21, 2, '0), "R6"); rd(21, "R6");
    wr(22, 4'b0110, pat(22, 3, '0), "R6"); rd(22, "R6"); rd(20, "R6"); idle(3);
    // R7 linear bursts
    nx_ilv = 0;
    rd(14, "R7"); for (int k = 0; k < 5; k++) nxt(1'b0, '0, "R7");
    idle(2);
    wr(49, '0, pat(49, 112, '0), "R7");
    for (int k = 1; k < 4; k++) nxt(1'b0, pat(49, 112 + k, '0), "R7");
    idle(3);
    for (int a = 48; a < 52; a++) rd(a, "R7");
    idle(3);
    // R8 interleaved burst
    nx_ilv = 1;
    rd(50, "R8"); for (int k = 0; k < 3; k++) nxt(1'b0, '0, "R8");
    wr(57, 4'b0000, pat(57, 7, '0), "R8"); nxt(1'b0, pat(57, 8, '0), "R8");
    idle(3); rd(56, "R8"); rd(57, "R8"); idle(3);
    nx_ilv = 0;
    // R9 burst direction kept, continue without burst ignored
    idle_tag = "R9";
    rd(0, "R9"); nxt(1'b1, pat(1, 200, '0), "R9"); nxt(1'b1, pat(2, 200, '0), "R9");
    idle(1);
    step(ACT, 1'b1, 1'b1, 7, '0, pat(7, 201, '0), "R9");
    idle(3); rd(1, "R9"); rd(7, "R9"); idle(3);
    // R1 chip enables
    idle_tag = "R1";
    step(3'b110, 1'b0, 1'b1, 40, '0, pat(40, 238, '0), "R1");
    step(3'b000, 1'b0, 1'b1, 41, '0, pat(41, 238, '0), "R1");
    step(3'b011, 1'b0, 1'b1, 42, '0, pat(42, 238, '0), "R1");
    step(3'b110, 1'b0, 1'b0, 40, '1, '0, "R1");
    step(3'b000, 1'b0, 1'b0, 41, '1, '0, "R1");
    step(3'b011, 1'b0, 1'b0, 42, '1, '0, "R1");
    idle(3); rd(40, "R1"); rd(41, "R1"); rd(42, "R1"); idle(3);
    // R10 asynchronous output enable
    idle_tag = "R10";
    nx_oe = 1; rd(30, "R10"); rd(31, "R10"); idle(2);
    nx_oe = 0; rd(31, "R10"); idle(3);
    nx_oe = 1; rd(32, "R10"); nx_oe = 0; idle(3);
    // R11 sleep
    idle_tag = "R11";
    nx_slp = 1; rd(33, "R11"); idle(2); nx_slp = 0; idle(2);
    wr(34, '0, pat(34, 68, '0), "R11"); nx_slp = 1; idle(2); nx_slp = 0; idle(2);
    rd(34, "R11"); rd(35, "R11"); nx_slp = 1; idle(2); nx_slp = 0; idle(3);
    idle_tag = "R1";
  endtask

  initial begin
    rst_n = 0; pipe_mode = 0; burst_ilv = 0; addr = '0; adv = 0; we_n = 1; bw_n = '1;
    ce1_n = 1; ce2 = 0; ce3_n = 1; oe_n = 0; sleep = 0; din = '0;
    cyc = 0; checks = 0; errors = 0;
    do_reset(1'b0); run_suite(); idle(4);
    do_reset(1'b1); run_suite(); idle(4);
    if (rq.size() != 0) begin
      checks++; errors++;
      $display("FAIL R2: %0d reads left unanswered, expected 0", rq.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL R13: watchdog expired at cycle %0d, expected completion", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule